// File: doc/BRIEF.md
# Binary Pattern Frequency Accumulator

This block builds the training histogram for a binary contour matcher. It takes a raster-scan stream of 8-bit grayscale pixels and reduces each pixel to a single black or white bit with a fixed luminosity threshold. At every interior position it assembles the surrounding 3×3 neighbourhood of bits into a 9-bit code, and it adds one to an on-chip counter selected by that code. When a frame ends, the 512 counters give the frequency of every neighbourhood pattern. A later entropy-based selection stage reads them and decides which patterns matter.

Pixels arrive on a valid/ready stream. A start-of-frame flag marks the first pixel of a frame and an end-of-line flag marks the last pixel of each row. When a start-of-frame pixel is offered, the block first zeroes every bin and the window total, then accepts the pixel. After that it takes one pixel per clock for the rest of the frame. A registered read port returns one bin per request, and a separate output shows how many windows were counted in the current frame.

Top module: `bpf_accum`

## Requirements
- R1: A pixel is white (bit 1) when its value is 150 or more and black (bit 0) when it is 149 or less.
- R2: The pattern code is the 3×3 window packed row by row, top row first and left to right within a row. Bit 8 is the top-left pixel and bit 0 is the bottom-right pixel.
- R3: Only windows whose centre is at least one pixel away from every frame edge are counted. A frame of W×H pixels adds exactly (W-2)·(H-2), and `total_cnt` equals that number once the frame has drained.
- R4: Outside a clear, `s_ready` stays high, so a frame streams in at one pixel per clock with no stall.
- R5: When a start-of-frame pixel is offered, `s_ready` is low for exactly 513 cycles (one cycle of decision plus 512 clear writes), provided the pipeline was idle. During that time every bin and `total_cnt` are zeroed, so no earlier frame leaks into the new histogram.
- R6: When the same code occurs on consecutive windows, every occurrence is counted, with no increment lost.
- R7: A bin stops at 2^CNT_W-1 and never wraps.
- R8: The value of bin `rd_addr` appears on `rd_data` one clock edge after the address is applied.
- R9: After reset, `total_cnt` is zero and `s_ready` is high while no start-of-frame pixel is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Pixel offered |
| s_ready | output | 1 | Block accepts the offered pixel this cycle |
| s_pix | input | PIX_W | Grayscale pixel value |
| s_sof | input | 1 | Offered pixel is the first pixel of a frame |
| s_eol | input | 1 | Offered pixel is the last pixel of its row |
| rd_addr | input | 9 | Histogram bin to read |
| rd_data | output | CNT_W | Count of bin `rd_addr`, one cycle later |
| total_cnt | output | $clog2(IMG_W·IMG_H+1) | Number of windows counted in the current frame |

## Verification
The assertions are checked on every cycle:
- No pixel is accepted while the clear is running.
- The clear-complete pulse only occurs during a clear.
- A start-of-frame pixel never produces a code on the following cycle.
- The window total rises by at most one per cycle.
- When the same bin is hit on consecutive cycles, the write value is exactly one above the previous write, unless the bin is saturated.
- A write never wraps a counter to zero.

Only the bench scenarios can show the complete histogram. It is compared bin by bin with a model computed from the raw pixels, over frames that are random, striped, saturating, threshold-edge and bubbled. The bench scenarios also cover the exact stall length of the clear, and the fact that a later frame starts from empty bins.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int CODE_W = 9;
  localparam int BINS   = 1 << CODE_W;

  // luminosity to binary: white at or above the threshold
  function automatic logic to_bit(input logic [7:0] pix, input logic [7:0] thr);
    return (pix >= thr);
  endfunction

  // columns are {top, mid, bottom}; c0 is the leftmost column
  function automatic logic [CODE_W-1:0] pack_win(input logic [2:0] c0,
                                                 input logic [2:0] c1,
                                                 input logic [2:0] c2);
    return {c0[2], c1[2], c2[2], c0[1], c1[1], c2[1], c0[0], c1[0], c2[0]};
  endfunction
endpackage

// File: rtl/bpf_window.sv
module bpf_window
  import bpf_pkg::*;
#(
  parameter int IMG_W  = 512,
  parameter int PIX_W  = 8,
  parameter int THRESH = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [PIX_W-1:0]  pix,
  input  logic              sof,
  input  logic              eol,
  output logic              code_vld,
  output logic [CODE_W-1:0] code
);
  localparam int COL_W = (IMG_W > 2) ? $clog2(IMG_W) : 1;

  logic [COL_W-1:0] col, cur_col;
  logic [1:0]       row, cur_row;
  logic [IMG_W-1:0] lb_prev, lb_prev2;
  logic [2:0]       w0, w1, cur;
  logic             pbit;

  assign cur_col = sof ? '0 : col;
  assign cur_row = sof ? 2'd0 : row;
  assign pbit    = to_bit(pix[7:0], 8'(THRESH));
  assign cur     = {lb_prev2[cur_col], lb_prev[cur_col], pbit};

  always_ff @(posedge clk) begin
    if (acc) begin
      lb_prev[cur_col]  <= pbit;
      lb_prev2[cur_col] <= lb_prev[cur_col];
      w1 <= cur;
      w0 <= w1;
      code <= pack_win(w0, w1, cur);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      row      <= 2'd0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= acc && (cur_row == 2'd2) && (cur_col >= COL_W'(2));
      if (acc) begin
        col <= eol ? '0 : cur_col + 1'b1;
        if (eol) row <= (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
        else     row <= cur_row;
      end
    end
  end

  // R3: the first pixel of a frame can never complete a window
  a_r3_no_code_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sof) |=> !code_vld);
endmodule

// File: rtl/bpf_histo.sv
module bpf_histo
  import bpf_pkg::*;
#(
  parameter int CNT_W = 18,
  parameter int TOT_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [CODE_W-1:0] in_code,
  input  logic              clr_req,
  output logic              clr_done,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [TOT_W-1:0]  total
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0]  mem [BINS];
  logic              vld1;
  logic [CODE_W-1:0] addr1;
  logic [CNT_W-1:0]  cur1, inc_val;
  logic              fwd_hit, clr_go;
  logic [CODE_W-1:0] clr_idx;

  assign inc_val  = sat_inc(cur1);
  assign fwd_hit  = in_vld && vld1 && (in_code == addr1);
  assign clr_go   = clr_req && !in_vld && !vld1;
  assign clr_done = clr_go && (clr_idx == CODE_W'(BINS - 1));

  always_ff @(posedge clk) begin
    if (clr_go)    mem[clr_idx] <= '0;
    else if (vld1) mem[addr1]   <= inc_val;
    cur1    <= fwd_hit ? inc_val : mem[in_code];
    addr1   <= in_code;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld1    <= 1'b0;
      clr_idx <= '0;
      total   <= '0;
    end else begin
      vld1 <= in_vld;
      if (clr_go) clr_idx <= clr_idx + 1'b1;
      if (clr_go && clr_idx == '0) total <= '0;
      else if (vld1)               total <= total + 1'b1;
    end
  end

  // R6: back-to-back hits on one bin advance by exactly one
  a_r6_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1 && $past(vld1) && addr1 == $past(addr1) && $past(inc_val) != MAXV)
      |-> inc_val == $past(inc_val) + 1'b1);
  // R7: a counter write never wraps to zero
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    vld1 |-> inc_val != '0);
  // R3: total grows by at most one per cycle outside a clear
  a_r3_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_go |=> (total == $past(total) || total == $past(total) + 1'b1));
endmodule

// File: rtl/bpf_accum.sv
module bpf_accum
  import bpf_pkg::*;
#(
  parameter int IMG_W  = 512,
  parameter int IMG_H  = 512,
  parameter int PIX_W  = 8,
  parameter int THRESH = 150,
  parameter int CNT_W  = 18,
  localparam int TOT_W = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_pix,
  input  logic              s_sof,
  input  logic              s_eol,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [TOT_W-1:0]  total_cnt
);
  typedef enum logic {ST_RUN, ST_CLR} st_t;
  st_t  st;
  logic armed, acc, clr_done, code_vld;
  logic [CODE_W-1:0] code;

  assign s_ready = (st == ST_RUN) && !(s_valid && s_sof && !armed);
  assign acc     = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      armed <= 1'b0;
    end else begin
      case (st)
        ST_RUN: if (s_valid && s_sof && !armed) st <= ST_CLR;
        ST_CLR: if (clr_done) st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
      if (clr_done)        armed <= 1'b1;
      else if (acc && s_sof) armed <= 1'b0;
    end
  end

  bpf_window #(.IMG_W(IMG_W), .PIX_W(PIX_W), .THRESH(THRESH)) u_win (
    .clk(clk), .rst_n(rst_n), .acc(acc), .pix(s_pix), .sof(s_sof),
    .eol(s_eol), .code_vld(code_vld), .code(code)
  );

  bpf_histo #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .in_vld(code_vld), .in_code(code),
    .clr_req(st == ST_CLR), .clr_done(clr_done), .rd_addr(rd_addr),
    .rd_data(rd_data), .total(total_cnt)
  );

  // R5: nothing enters while bins are being zeroed
  a_r5_no_accept_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLR) |-> !acc);
  // R5: clear completion only happens inside a clear
  a_r5_done_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |-> (st == ST_CLR));
endmodule

// File: tb/bpf_accum_tb.sv
module bpf_accum_tb;
  localparam int W = 10, H = 6, CW = 5;
  localparam int TW = $clog2(W * H + 1);
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_sof = 0, s_eol = 0;
  logic [7:0] s_pix = 0;
  logic s_ready;
  logic [8:0] rd_addr = 0;
  logic [CW-1:0] rd_data;
  logic [TW-1:0] total_cnt;

  int total = 0, bad = 0;
  bit finished = 0;
  int fr [H][W];
  int exp_h [512];

  always #10 clk = ~clk;

  bpf_accum #(.IMG_W(W), .IMG_H(H), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_pix(s_pix), .s_sof(s_sof), .s_eol(s_eol), .rd_addr(rd_addr),
    .rd_data(rd_data), .total_cnt(total_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: binarize, slide every interior 3x3 window, saturate
  task automatic model();
    for (int i = 0; i < 512; i++) exp_h[i] = 0;
    for (int r = 1; r < H - 1; r++)
      for (int c = 1; c < W - 1; c++) begin
        int k = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            k = (k << 1) | ((fr[r+dr][c+dc] >= 150) ? 1 : 0);
        if (exp_h[k] < MAXC) exp_h[k]++;
      end
  endtask

  task automatic send_frame(input bit bubbles);
    int clr_stall = 0, run_stall = 0;
    repeat (4) @(negedge clk);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        bit got = 0;
        if (bubbles && r + c > 0) begin
          s_valid = 0;
          repeat ($urandom % 2) @(negedge clk);
        end
        s_valid = 1; s_pix = 8'(fr[r][c]);
        s_sof = (r == 0 && c == 0); s_eol = (c == W - 1);
        while (!got) begin
          #1;
          got = s_ready;
          if (!got) begin
            if (r == 0 && c == 0) clr_stall++; else run_stall++;
          end
          @(negedge clk);
        end
      end
    s_valid = 0; s_sof = 0; s_eol = 0;
    check("R5 clear stall cycles", clr_stall, 513);
    check("R4 stalls inside frame", run_stall, 0);
  endtask

  task automatic verify_hist(input string tag);
    repeat (4) @(negedge clk);
    check({tag, " R3 total windows"}, int'(total_cnt), (W - 2) * (H - 2));
    for (int b = 0; b < 512; b++) begin
      rd_addr = 9'(b);
      @(negedge clk); // R8: one edge of latency
      check({tag, " R8/R2 bin"}, int'(rd_data), exp_h[b]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 ready after reset", int'(s_ready), 1);
    check("R9 total after reset", int'(total_cnt), 0);

    // random grayscale frame, exercises R1/R2/R3
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = $urandom % 256;
    model(); send_frame(0); verify_hist("random");

    // threshold edge checkerboard 149/150: R1
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = ((r + c) % 2) ? 150 : 149;
    model(); send_frame(0); verify_hist("R1 edge");
    check("R1 checker code 0x155", exp_h[9'h155] + exp_h[9'h0AA], (W - 2) * (H - 2));

    // horizontal stripes: long runs of one code, R6 forwarding; R2 codes
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = (r < 3) ? 255 : 0;
    model(); send_frame(0); verify_hist("R6 stripes");
    check("R2 stripe code 0x1F8", exp_h[9'h1F8], W - 2);

    // all white: 32 hits on bin 511, R7 saturation
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = 255;
    model(); send_frame(0); verify_hist("R7 white");
    check("R7 saturated bin", exp_h[511], MAXC);

    // all black: bin 511 must read zero after clear, R5
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = $urandom % 150;
    model(); send_frame(0); verify_hist("R5 black");

    // random frame with idle gaps between pixels
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++) fr[r][c] = $urandom % 256;
    model(); send_frame(1); verify_hist("R3 bubbles");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule